// File: doc/BRIEF.md
# FIFO Status Flag Generator

This block watches the fill levels of a radio's receive and transmit byte FIFOs and turns them into six status flags. It also watches a few event strobes. Each flag has its own set condition and its own clear condition. A plain level compare follows the fill level directly. Other flags latch and then release only at a lower level, or latch on an event and hold until the FIFO is flushed. A 3-bit selector picks one flag for the single status output, and an optional invert stage follows the selector. The thresholds, the selector and the invert bit are expected to come from a register bank outside the block. The fill levels and strobes come from the FIFO and packet logic.

Every flag lives in its own set/clear register in one clock domain. The status output is registered again after the selector. A change on a level or strobe input reaches the output two clock edges later. A change on the selector or the invert bit reaches it one edge later. The flag state is updated in every mode, so a new selection always shows the flag's current value.

Top module: `fifo_flag_gen`

## Requirements
- R1: With select code 0, the flag is high when the RX fill level is greater than or equal to the RX threshold, and low otherwise.
- R2: With select code 1, the flag sets when the RX level is at or above the RX threshold or when the end-of-packet strobe is high. It clears only when the RX level is 0. If set and clear are true in the same cycle, set wins.
- R3: With select code 2, the flag is high when the TX fill level is greater than or equal to the TX threshold, and low otherwise.
- R4: With select code 3, the flag sets when the TX level equals DEPTH (full). It stays set until the TX level falls below the TX threshold.
- R5: With select code 4, an RX overflow strobe sets a sticky flag that only an RX flush clears. When both are high in one cycle, the flush wins. A TX flush has no effect on this flag.
- R6: With select code 5, a TX underflow strobe sets a sticky flag that only a TX flush clears. When both are high in one cycle, the flush wins.
- R7: All six flags update whatever the select code is. Selecting a flag after its events shows its current state.
- R8: When the invert input is 1, the selected flag is inverted at the output. Inversion leaves the flag state unchanged, so clearing invert shows the original value again.
- R9: Select codes 6 and 7 drive a low flag, so the output equals the invert input.
- R10: A level or strobe change appears at the output after two rising edges. A select or invert change appears after one rising edge.
- R11: A synchronous active-high reset clears all flag state and the output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | LVL_W = clog2(DEPTH+1) | RX FIFO fill level in bytes, 0..DEPTH |
| tx_level | input | LVL_W | TX FIFO fill level in bytes, 0..DEPTH |
| rx_thresh | input | THR_W = clog2(DEPTH) | RX threshold in bytes |
| tx_thresh | input | THR_W | TX threshold in bytes |
| eop_strobe | input | 1 | End-of-packet pulse from the receive path |
| rx_ovf_evt | input | 1 | RX overflow pulse |
| tx_udf_evt | input | 1 | TX underflow pulse |
| rx_flush | input | 1 | RX FIFO flush command |
| tx_flush | input | 1 | TX FIFO flush command |
| mode_sel | input | 3 | Flag selector, codes 0..5 as in R1..R6, 6 and 7 select low |
| invert | input | 1 | Output polarity invert |
| status_out | output | 1 | Registered selected flag |

## Verification
The bench builds the block with DEPTH = 16. That gives 5-bit levels and 4-bit thresholds. With this depth the full condition, the largest threshold and the empty level can each be reached with small directed values. It also checks that the derived widths line up when the depth is not the default. Each test sets the thresholds near the values where a flag changes state, so that the asymmetric release points in R2 and R4 are checked one count above and one count below. The sticky flags are driven while a different flag is selected. The bench also drives set and flush in the same cycle.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RX_LEVEL = 3'd0,
    SEL_RX_PKT   = 3'd1,
    SEL_TX_LEVEL = 3'd2,
    SEL_TX_FULL  = 3'd3,
    SEL_RX_OVF   = 3'd4,
    SEL_TX_UDF   = 3'd5,
    SEL_LOW_A    = 3'd6,
    SEL_LOW_B    = 3'd7
  } flag_sel_e;

  // One bit per flag: 1 means clear has priority over set.
  localparam logic [NUM_FLAGS-1:0] CLEAR_FIRST = 6'b11_0000;
endpackage

// File: rtl/flag_conds.sv
module flag_conds
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [LVL_W-1:0]     tx_level,
  input  logic [THR_W-1:0]     rx_thresh,
  input  logic [THR_W-1:0]     tx_thresh,
  input  logic                 eop_strobe,
  input  logic                 rx_ovf_evt,
  input  logic                 tx_udf_evt,
  input  logic                 rx_flush,
  input  logic                 tx_flush,
  output logic [NUM_FLAGS-1:0] set_vec,
  output logic [NUM_FLAGS-1:0] clr_vec
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic rx_at_thr, tx_at_thr, rx_empty, tx_full;

  always_comb begin
    rx_at_thr = rx_level >= LVL_W'(rx_thresh);
    tx_at_thr = tx_level >= LVL_W'(tx_thresh);
    rx_empty  = rx_level == '0;
    tx_full   = tx_level >= FULL_LVL;

    set_vec[SEL_RX_LEVEL] = rx_at_thr;
    clr_vec[SEL_RX_LEVEL] = !rx_at_thr;

    set_vec[SEL_RX_PKT]   = rx_at_thr || eop_strobe;
    clr_vec[SEL_RX_PKT]   = rx_empty;

    set_vec[SEL_TX_LEVEL] = tx_at_thr;
    clr_vec[SEL_TX_LEVEL] = !tx_at_thr;

    set_vec[SEL_TX_FULL]  = tx_full;
    clr_vec[SEL_TX_FULL]  = !tx_at_thr;

    set_vec[SEL_RX_OVF]   = rx_ovf_evt;
    clr_vec[SEL_RX_OVF]   = rx_flush;

    set_vec[SEL_TX_UDF]   = tx_udf_evt;
    clr_vec[SEL_TX_UDF]   = tx_flush;
  end
endmodule

// File: rtl/setclr_flag.sv
module setclr_flag #(
  parameter bit CLR_PRIO = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (CLR_PRIO) begin
      if (clr_i)      flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
    end else begin
      if (set_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_select.sv
module flag_select
  import fifo_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 inv_i,
  output logic                 out_o
);
  localparam int SLOTS = 2 ** SEL_W;

  logic [SLOTS-1:0] slot_vec;
  logic             picked;

  always_comb begin
    slot_vec = SLOTS'(flags_i);
    picked   = slot_vec[sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) out_o <= 1'b0;
    else     out_o <= picked ^ inv_i;
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [THR_W-1:0] rx_thresh,
  input  logic [THR_W-1:0] tx_thresh,
  input  logic             eop_strobe,
  input  logic             rx_ovf_evt,
  input  logic             tx_udf_evt,
  input  logic             rx_flush,
  input  logic             tx_flush,
  input  logic [2:0]       mode_sel,
  input  logic             invert,
  output logic             status_out
);
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_q;

  flag_conds #(.DEPTH(DEPTH)) u_conds (
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_thresh  (rx_thresh),
    .tx_thresh  (tx_thresh),
    .eop_strobe (eop_strobe),
    .rx_ovf_evt (rx_ovf_evt),
    .tx_udf_evt (tx_udf_evt),
    .rx_flush   (rx_flush),
    .tx_flush   (tx_flush),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    setclr_flag #(.CLR_PRIO(CLEAR_FIRST[g])) u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_q[g])
    );
  end

  flag_select u_sel (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flag_q),
    .sel_i   (mode_sel),
    .inv_i   (invert),
    .out_o   (status_out)
  );
endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic [THR_W-1:0] rx_thresh,
  input logic [THR_W-1:0] tx_thresh,
  input logic             eop_strobe,
  input logic             rx_ovf_evt,
  input logic             tx_udf_evt,
  input logic             rx_flush,
  input logic             tx_flush,
  input logic [2:0]       mode_sel,
  input logic             invert,
  input logic [5:0]       flag_q,
  input logic             status_out
);
  logic [1:0] warm;
  logic [7:0] flag8;

  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  always_comb flag8 = {2'b00, flag_q};

  assert_rx_level_R1: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(mode_sel) == 3'd0 && !$past(invert))
      |-> status_out == ($past(rx_level, 2) >= LVL_W'($past(rx_thresh, 2))));

  assert_pkt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] && rx_level != '0) |=> flag_q[1]);

  assert_pkt_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 && rx_thresh != '0 && !eop_strobe) |=> !flag_q[1]);

  assert_tx_level_R3: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(mode_sel) == 3'd2 && !$past(invert))
      |-> status_out == ($past(tx_level, 2) >= LVL_W'($past(tx_thresh, 2))));

  assert_full_set_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_level == LVL_W'(DEPTH)) |=> flag_q[3]);

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_q[3] && tx_level >= LVL_W'(tx_thresh)) |=> flag_q[3]);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ((rx_ovf_evt || flag_q[4]) && !rx_flush) |=> flag_q[4]);

  assert_ovf_flush_R5: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> !flag_q[4]);

  assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ((tx_udf_evt || flag_q[5]) && !tx_flush) |=> flag_q[5]);

  assert_udf_flush_R6: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> !flag_q[5]);

  assert_select_invert_R8: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1) |-> status_out == ($past(invert) ^ $past(flag8[mode_sel])));

  assert_low_codes_R9: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && $past(mode_sel) >= 3'd6) |-> status_out == $past(invert));

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && !status_out));
endmodule

bind fifo_flag_gen fifo_flag_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
  .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .eop_strobe(eop_strobe),
  .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt), .rx_flush(rx_flush),
  .tx_flush(tx_flush), .mode_sel(mode_sel), .invert(invert),
  .flag_q(flag_q), .status_out(status_out)
);

// File: tb/test_fifo_flag_gen.sv
module test_fifo_flag_gen;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int THR_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic [THR_W-1:0] rx_thresh = '0, tx_thresh = '0;
  logic eop_strobe = 1'b0, rx_ovf_evt = 1'b0, tx_udf_evt = 1'b0;
  logic rx_flush = 1'b0, tx_flush = 1'b0, invert = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic status_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fifo_flag_gen #(.DEPTH(DEPTH)) i_fifo_flag_gen (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .eop_strobe(eop_strobe),
    .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .mode_sel(mode_sel), .invert(invert),
    .status_out(status_out)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (status_out !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, status_out, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic one_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rx_level = 5'd9; mode_sel = 3'd0; rx_thresh = 4'd2;
    repeat (3) one_edge();
    check(1'b0, "R11 output low in reset");
    rst = 1'b0;
    settle();
    check(1'b1, "R11 leaves reset and follows level");
    rx_level = '0;
    settle();
  endtask

  task automatic t_rx_level();
    mode_sel = 3'd0; rx_thresh = 4'd8;
    rx_level = 5'd7;  settle(); check(1'b0, "R1 level 7 thr 8");
    rx_level = 5'd8;  settle(); check(1'b1, "R1 level 8 thr 8");
    rx_level = 5'd16; settle(); check(1'b1, "R1 level 16 thr 8");
    rx_level = 5'd7;  settle(); check(1'b0, "R1 drop to 7");
  endtask

  task automatic t_latency();
    mode_sel = 3'd0; rx_thresh = 4'd4; rx_level = 5'd0; settle();
    rx_level = 5'd6;
    one_edge(); check(1'b0, "R10 one edge after level change");
    one_edge(); check(1'b1, "R10 two edges after level change");
    mode_sel = 3'd6;
    one_edge(); check(1'b0, "R10 one edge after select change");
    rx_level = 5'd0; mode_sel = 3'd0; settle();
  endtask

  task automatic t_rx_pkt();
    mode_sel = 3'd1; rx_thresh = 4'd8; rx_level = 5'd3; settle();
    check(1'b0, "R2 below thr no eop");
    eop_strobe = 1'b1; one_edge(); eop_strobe = 1'b0; settle();
    check(1'b1, "R2 eop sets");
    rx_level = 5'd1; settle(); check(1'b1, "R2 holds at level 1");
    rx_level = 5'd0; settle(); check(1'b0, "R2 clears at empty");
    rx_level = 5'd9; settle(); check(1'b1, "R2 threshold sets");
    rx_level = 5'd2; settle(); check(1'b1, "R2 holds below thr");
    rx_level = 5'd0; eop_strobe = 1'b1; one_edge(); eop_strobe = 1'b0;
    one_edge(); check(1'b1, "R2 eop on empty, set wins");
    settle(); check(1'b0, "R2 empty clears afterwards");
  endtask

  task automatic t_tx_level();
    mode_sel = 3'd2; tx_thresh = 4'd5;
    tx_level = 5'd4; settle(); check(1'b0, "R3 level 4 thr 5");
    tx_level = 5'd5; settle(); check(1'b1, "R3 level 5 thr 5");
    tx_level = 5'd3; settle(); check(1'b0, "R3 drop to 3");
  endtask

  task automatic t_tx_full();
    mode_sel = 3'd3; tx_thresh = 4'd10;
    tx_level = 5'd12; settle(); check(1'b0, "R4 above thr not full");
    tx_level = 5'd16; settle(); check(1'b1, "R4 full sets");
    tx_level = 5'd10; settle(); check(1'b1, "R4 holds at thr");
    tx_level = 5'd9;  settle(); check(1'b0, "R4 clears below thr");
    tx_level = 5'd0;  settle();
  endtask

  task automatic t_sticky();
    mode_sel = 3'd0; rx_level = 5'd0; rx_thresh = 4'd8;
    rx_ovf_evt = 1'b1; one_edge(); rx_ovf_evt = 1'b0; settle();
    mode_sel = 3'd4; settle(); check(1'b1, "R7 overflow seen after switch");
    tx_flush = 1'b1; one_edge(); tx_flush = 1'b0; settle();
    check(1'b1, "R5 tx flush ignored");
    rx_flush = 1'b1; one_edge(); rx_flush = 1'b0; settle();
    check(1'b0, "R5 rx flush clears");
    rx_ovf_evt = 1'b1; rx_flush = 1'b1; one_edge();
    rx_ovf_evt = 1'b0; rx_flush = 1'b0; settle();
    check(1'b0, "R5 flush wins over overflow");
    mode_sel = 3'd5;
    tx_udf_evt = 1'b1; one_edge(); tx_udf_evt = 1'b0; settle();
    check(1'b1, "R6 underflow sets");
    tx_udf_evt = 1'b1; tx_flush = 1'b1; one_edge();
    tx_udf_evt = 1'b0; tx_flush = 1'b0; settle();
    check(1'b0, "R6 flush wins and clears");
  endtask

  task automatic t_invert();
    mode_sel = 3'd0; rx_thresh = 4'd8; rx_level = 5'd2; invert = 1'b1; settle();
    check(1'b1, "R8 inverted low flag");
    invert = 1'b0; settle(); check(1'b0, "R8 state unchanged by invert");
    mode_sel = 3'd6; settle(); check(1'b0, "R9 code 6 low");
    invert = 1'b1; mode_sel = 3'd7; settle(); check(1'b1, "R9 code 7 inverted");
    invert = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rx_level();
    t_latency();
    t_rx_pkt();
    t_tx_level();
    t_tx_full();
    t_sticky();
    t_invert();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule